// File: doc/BRIEF.md
# Serial Word Manchester Encoder

This block turns one 16-bit payload into a complete serial word for a bipolar differential bus. The word starts with a three-bit-time synchronisation pattern that is not Manchester coded. Its polarity tells a receiver whether the word is a command/status word or a data word. Sixteen Manchester-coded data bits follow, and the word ends with an odd parity bit. The block drives the bus through a pair of drive-high and drive-low lines and an output enable. An external transceiver turns these into the analog line levels.

A sequencer hands over each word through a valid/ready handshake. A select input goes with the payload and picks the sync type. The block pulses a done flag in the final clock of the last half-bit. If the next word is offered at that moment, it is taken at once and starts with no idle gap. If no word is waiting, the output enable drops. The half-bit length is set by a parameter in clock cycles, so a 1 Mbit/s rate follows from the system clock.

Top module: `mwe_word_tx`

## Requirements
- R1: A word is 40 half-bits of CLK_PER_HALF clock cycles each. The first half-bit is driven in the first cycle after the word is accepted.
- R2: When the select input is 1 at acceptance (command/status sync), the first three half-bits are positive and the next three are negative. When it is 0 (data sync), the sync is the inverse.
- R3: After the sync, the 16 payload bits are sent most significant bit first. A 1 is a positive half-bit then a negative half-bit, and a 0 is the reverse.
- R4: The final bit time carries a parity bit, coded like a data bit. The parity bit makes the total number of ones in payload plus parity odd.
- R5: `in_ready` is high when the block is idle or in the final clock of a word, and low otherwise. Payload and select changes while `in_ready` is low have no effect on the word being sent.
- R6: `word_done` is high for exactly one cycle, the final clock of the 40th half-bit, and low at all other times.
- R7: A word offered while `word_done` is high is accepted at that edge. Its first sync half-bit follows in the next cycle with `bus_oe` staying high.
- R8: When no word is offered at the end of a word, `bus_oe`, `bus_hi` and `bus_lo` are all low from the next cycle.
- R9: A positive half-bit drives `bus_hi`=1, `bus_lo`=0, and a negative half-bit drives the reverse. Both are 0 when `bus_oe` is 0, and they are never both 1.
- R10: Synchronous reset `rst` abandons any word in progress and returns the block to idle at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A payload is offered |
| in_ready | output | 1 | Block takes the offered payload at this edge |
| in_data | input | 16 | Payload, most significant bit sent first |
| in_cmd_sync | input | 1 | 1 = command/status sync, 0 = data sync |
| bus_hi | output | 1 | Drive bus positive |
| bus_lo | output | 1 | Drive bus negative |
| bus_oe | output | 1 | Bus driver enable |
| word_done | output | 1 | Final clock of the last half-bit |

## Verification
The hardest case is the seam between two words. The old word's last parity half-bit must hand over to the new word's sync in one clock, with the enable held high. The bench keeps `in_valid` high across a table of payloads and checks every cycle of every word against a waveform model built from the requirements. Each boundary is therefore an unbroken join. The payload is changed to the next entry right after each acceptance, so any mid-word sampling of the inputs shows up as a corrupted word.

// File: rtl/mwe_pkg.sv
package mwe_pkg;
  // Sync field length in half-bits (three bit times)
  localparam int SYNC_HALVES = 6;
  // Parity bit length in half-bits
  localparam int PAR_HALVES  = 2;

  typedef enum logic {
    SYNC_DATA = 1'b0,
    SYNC_CMD  = 1'b1
  } sync_kind_e;
endpackage

// File: rtl/mwe_tick_gen.sv
module mwe_tick_gen #(
  parameter int CLK_PER_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  generate
    if (CLK_PER_HALF == 1) begin : g_every
      assign tick = run;
    end else begin : g_count
      localparam int CW = $clog2(CLK_PER_HALF);
      localparam logic [CW-1:0] LAST = CW'(CLK_PER_HALF - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst || !run)     cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
      end
      assign tick = run && (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/mwe_sym_build.sv
// Builds the full half-bit level pattern of a word, first half-bit in the MSB.
module mwe_sym_build
  import mwe_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int NH = SYNC_HALVES + 2*DATA_W + PAR_HALVES
) (
  input  logic [DATA_W-1:0] data,
  input  sync_kind_e        kind,
  output logic [NH-1:0]     pat
);
  logic par;
  assign par = ~(^data);

  localparam int HS = SYNC_HALVES / 2;
  assign pat[NH-1 -: HS]      = {HS{kind == SYNC_CMD}};
  assign pat[NH-1-HS -: HS]   = {HS{kind != SYNC_CMD}};

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam int POS = NH - 1 - SYNC_HALVES - 2*i;
    assign pat[POS]   = data[DATA_W-1-i];
    assign pat[POS-1] = ~data[DATA_W-1-i];
  end

  assign pat[1] = par;
  assign pat[0] = ~par;
endmodule

// File: rtl/mwe_word_tx.sv
module mwe_word_tx
  import mwe_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int CLK_PER_HALF = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_cmd_sync,
  output logic              bus_hi,
  output logic              bus_lo,
  output logic              bus_oe,
  output logic              word_done
);
  localparam int NH = SYNC_HALVES + 2*DATA_W + PAR_HALVES;
  localparam int HW = $clog2(NH);
  localparam logic [HW-1:0] LAST_HALF = HW'(NH - 1);

  logic          active;
  logic [NH-1:0] pat_q;
  logic [NH-1:0] pat_new;
  logic [HW-1:0] half_q;
  logic          tick;
  logic          accept;
  sync_kind_e    kind;

  assign kind = in_cmd_sync ? SYNC_CMD : SYNC_DATA;

  mwe_sym_build #(.DATA_W(DATA_W)) u_sym (
    .data (in_data),
    .kind (kind),
    .pat  (pat_new)
  );

  mwe_tick_gen #(.CLK_PER_HALF(CLK_PER_HALF)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (active),
    .tick (tick)
  );

  assign word_done = active && tick && (half_q == LAST_HALF);
  assign in_ready  = !active || word_done;
  assign accept    = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      pat_q  <= '0;
      half_q <= '0;
    end else if (accept) begin
      active <= 1'b1;
      pat_q  <= pat_new;
      half_q <= '0;
    end else if (word_done) begin
      active <= 1'b0;
    end else if (tick) begin
      pat_q  <= {pat_q[NH-2:0], 1'b0};
      half_q <= half_q + 1'b1;
    end
  end

  assign bus_oe = active;
  assign bus_hi = active &&  pat_q[NH-1];
  assign bus_lo = active && !pat_q[NH-1];
endmodule

// File: rtl/mwe_word_tx_chk.sv
module mwe_word_tx_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              in_cmd_sync,
  input logic              bus_hi,
  input logic              bus_lo,
  input logic              bus_oe,
  input logic              word_done
);
  a_r9_never_both: assert property (@(posedge clk) disable iff (rst)
    !(bus_hi && bus_lo));
  a_r9_one_when_on: assert property (@(posedge clk) disable iff (rst)
    $countones({bus_hi, bus_lo}) == (bus_oe ? 1 : 0));
  a_r2_first_half: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (bus_oe && bus_hi == $past(in_cmd_sync)));
  a_r5_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    (bus_oe && !word_done) |-> !in_ready);
  a_r6_done_when_on: assert property (@(posedge clk) disable iff (rst)
    word_done |-> bus_oe);
  a_r7_no_gap: assert property (@(posedge clk) disable iff (rst)
    (word_done && in_valid) |=> bus_oe);
  a_r8_drop: assert property (@(posedge clk) disable iff (rst)
    (word_done && !in_valid) |=> !bus_oe);
endmodule

bind mwe_word_tx mwe_word_tx_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/mwe_word_tx_tb.sv
module mwe_word_tx_tb;
  localparam int PERIOD = 10;
  localparam int CPH    = 4;
  localparam int NH     = 40;
  localparam int WC     = NH * CPH;
  localparam int NV     = 6;
  // {expected parity, cmd sync, payload}
  localparam logic [17:0] VEC [0:NV-1] = '{
    {1'b1, 1'b1, 16'h0000},
    {1'b1, 1'b0, 16'hFFFF},
    {1'b1, 1'b1, 16'hA5C3},
    {1'b0, 1'b0, 16'h0001},
    {1'b0, 1'b1, 16'h8000},
    {1'b1, 1'b0, 16'h7E81}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [15:0] in_data = '0;
  logic in_cmd_sync = 1'b0;
  logic bus_hi, bus_lo, bus_oe, word_done;
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  mwe_word_tx #(.DATA_W(16), .CLK_PER_HALF(CPH)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_cmd_sync(in_cmd_sync), .bus_hi(bus_hi),
    .bus_lo(bus_lo), .bus_oe(bus_oe), .word_done(word_done)
  );

  function automatic logic exp_lvl(int c, logic [17:0] v);
    int h;
    h = c / CPH;
    if (h < 3)       return v[16];
    else if (h < 6)  return ~v[16];
    else if (h < 38) begin
      logic b;
      b = v[15 - (h-6)/2];
      return ((h-6) % 2 == 0) ? b : ~b;
    end
    else if (h == 38) return v[17];
    else              return ~v[17];
  endfunction

  task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {oe,hi,lo,ready,done} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Checks cycle c of a word; at c==0 moves the inputs to the next request.
  task automatic watch_word(logic [17:0] v, bit more, logic [17:0] nxt);
    for (int c = 0; c < WC; c++) begin
      logic l;
      bit last;
      @(negedge clk);
      if (c == 0) begin
        in_valid    = more;
        in_data     = more ? nxt[15:0] : ~v[15:0];
        in_cmd_sync = more ? nxt[16] : ~v[16];
      end
      l = exp_lvl(c, v);
      last = (c == WC-1);
      // R1 R2 R3 R4 R5 R6 R9: full waveform, ready and done per cycle
      chk((c/CPH < 6) ? "R2" : (c/CPH < 38) ? "R3" : "R4",
          {bus_oe, bus_hi, bus_lo, in_ready, word_done},
          {1'b1, l, ~l, last, last});
      if (!last) @(posedge clk);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 R9: idle outputs during reset
    chk("R8", {bus_oe, bus_hi, bus_lo, in_ready, word_done}, 5'b00010);
    rst = 1'b0;
    @(negedge clk);
    chk("R8", {bus_oe, bus_hi, bus_lo, in_ready, word_done}, 5'b00010);

    // Table walk: back-to-back words, R7 no gap between them
    in_valid = 1'b1; in_data = VEC[0][15:0]; in_cmd_sync = VEC[0][16];
    for (int w = 0; w < NV; w++) begin
      @(posedge clk);
      watch_word(VEC[w], w < NV-1, (w < NV-1) ? VEC[w+1] : VEC[w]);
    end
    // R8: enable drops after the final word
    @(negedge clk);
    chk("R8", {bus_oe, bus_hi, bus_lo, in_ready, word_done}, 5'b00010);
    repeat (5) @(negedge clk);
    chk("R8", {bus_oe, bus_hi, bus_lo, in_ready, word_done}, 5'b00010);

    // R10: reset in the middle of a word
    in_valid = 1'b1; in_data = 16'h1234; in_cmd_sync = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (50) @(negedge clk);
    chk("R10", {bus_oe, 2'b00, in_ready, word_done}, 5'b10000);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10", {bus_oe, bus_hi, bus_lo, in_ready, word_done}, 5'b00010);

    // R1 R5: isolated word after idle, inputs toggled while busy
    @(negedge clk);
    in_valid = 1'b1; in_data = 16'hC001; in_cmd_sync = 1'b0;
    @(posedge clk);
    watch_word({1'b0, 1'b0, 16'hC001}, 1'b0, '0);
    @(negedge clk);
    chk("R8", {bus_oe, bus_hi, bus_lo, in_ready, word_done}, 5'b00010);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule